// File: doc/BRIEF.md
# PCI DMA Address Translation Unit

This block turns a 32-bit address presented by a PCI bus master into a 34-bit system memory address for DMA. Two address windows are compared against each incoming address. A window that claims the address maps it in one of two ways. In the linear way, the window's offset bits are merged into a page frame held in a register. In the table-walk way, a map entry is read from memory and supplies the page frame. The 8 KB page offset always passes through untouched.

Table-walk results are kept in a small fully associative buffer, so that repeated accesses to the same page need no memory read. On a buffer miss the unit raises a one-cycle read request for the map entry and stalls. It holds off new requests until the entry returns, then responds and stores the result.

Every response also trims the requested burst length so that the burst ends at the 8 KB page boundary. It flags whether the remainder must be issued as a separate transfer. The PCI side offers one request at a time with a strobe, and waits for the one-cycle response pulse.

Top module: `pci_dma_xlate`

## Requirements
- R1: After synchronous reset, req_ready is 1, rsp_valid is 0, mem_rd_req is 0, the translation buffer holds no valid entry, and its replacement pointer is at entry 0.
- R2: Each window w is written through cfg_we with cfg_win=w. The cfg_sel codes are: 0 = control (wdata[0] enable, wdata[1] table-walk mode), 1 = base (wdata[31:13]), 2 = mask (wdata[31:13], a 1 marks a bit that lies inside the window), 3 = translation register (wdata[30:0]). Window w claims an address when it is enabled and (addr[31:13] & ~mask) == (base & ~mask). Window 0 wins when both claim. An unclaimed address gives rsp_hit=0, with rsp_addr=0, rsp_len=0 and rsp_split=0.
- R3: In linear mode, rsp_addr[33:13] = (xlat[20:0] & ~mask) | (addr[31:13] & mask), and rsp_addr[12:0] = addr[12:0]. No memory read is issued, and the response comes two clock edges after the accepting edge.
- R4: In table-walk mode, the map entry address is {(xlat & ~mask) | (addr[31:13] & mask), 3'b000}, with the mask zero-extended to 31 bits. The translated address is {mem_rd_data[20:0], addr[12:0]}.
- R5: The buffer is tagged by window number and addr[31:13]. A table-walk request whose tag is held responds two edges after acceptance with the stored frame and issues no memory read.
- R6: On a buffer miss, mem_rd_req pulses for one cycle and req_ready stays 0 until the response. The response appears on the edge that samples mem_rd_valid, whatever the read delay.
- R7: The buffer has 8 entries, filled in round-robin order starting at entry 0. The ninth distinct page replaces the first, and all other pages remain.
- R8: tlb_inv clears every entry and returns the replacement pointer to 0. When it coincides with a fill, the invalidate wins: the response still carries the fetched frame, but that page misses again on the next request.
- R9: With room = 8192 - addr[12:0], rsp_len = min(req_len, room), and rsp_split = 1 exactly when req_len > room.
- R10: rsp_valid lasts one cycle per accepted request. A req_valid presented while req_ready is 0 is ignored and produces no response, read or fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_win | input | 1 | Window number for the write |
| cfg_sel | input | 2 | Register select within the window |
| cfg_wdata | input | 32 | Register write data |
| tlb_inv | input | 1 | Invalidate all translation buffer entries |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Unit idle and able to accept a request |
| req_addr | input | 32 | PCI address to translate |
| req_len | input | 14 | Requested burst length in bytes |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Address claimed by a window |
| rsp_addr | output | 34 | Translated system address |
| rsp_len | output | 14 | Burst length trimmed at the page end |
| rsp_split | output | 1 | Remainder of the burst lies in a later page |
| mem_rd_req | output | 1 | Map entry read request pulse |
| mem_rd_addr | output | 34 | Map entry address |
| mem_rd_valid | input | 1 | Map entry data valid |
| mem_rd_data | input | 21 | Page frame returned from the map entry |

## Verification
The case that needs care is a software invalidate in the same cycle as a miss refill: the buffer receives a clear and a write in one edge. The bench provokes this by having its memory model raise tlb_inv together with mem_rd_valid. It then judges the result at the ports: the response must still carry the fetched frame, and a second request to the same page must cause a fresh map read. A second overlap sends a stray request strobe during a long miss stall. It must yield neither a second response nor a buffer entry for the stray page.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    localparam int PCI_AW = 32;
    localparam int SYS_AW = 34;
    localparam int PG_W   = 13;
    localparam int VPN_W  = PCI_AW - PG_W;
    localparam int PFN_W  = SYS_AW - PG_W;
    localparam int ENT_W  = 3;
    localparam int TBL_W  = SYS_AW - ENT_W;
    localparam int LEN_W  = PG_W + 1;
    localparam int NWIN   = 2;
    localparam int WIN_IW = (NWIN > 1) ? $clog2(NWIN) : 1;
    localparam int TAG_W  = WIN_IW + VPN_W;

    typedef enum logic [1:0] {
        CF_CTRL = 2'd0,
        CF_BASE = 2'd1,
        CF_MASK = 2'd2,
        CF_XLAT = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_WAIT = 2'd2
    } xl_state_e;

    typedef struct packed {
        logic             en;
        logic             sg;
        logic [VPN_W-1:0] base;
        logic [VPN_W-1:0] mask;
        logic [TBL_W-1:0] xlat;
    } win_cfg_t;

    typedef struct packed {
        logic              hit;
        logic [SYS_AW-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              split;
    } xl_rsp_t;

    function automatic logic [PFN_W-1:0] linear_pfn(
        input logic [TBL_W-1:0] xl,
        input logic [VPN_W-1:0] mask,
        input logic [VPN_W-1:0] vpn
    );
        logic [PFN_W-1:0] m;
        m = {{(PFN_W-VPN_W){1'b0}}, mask};
        return (xl[PFN_W-1:0] & ~m) | {{(PFN_W-VPN_W){1'b0}}, vpn & mask};
    endfunction

    function automatic logic [SYS_AW-1:0] entry_addr(
        input logic [TBL_W-1:0] xl,
        input logic [VPN_W-1:0] mask,
        input logic [VPN_W-1:0] vpn
    );
        logic [TBL_W-1:0] m;
        m = {{(TBL_W-VPN_W){1'b0}}, mask};
        return {(xl & ~m) | {{(TBL_W-VPN_W){1'b0}}, vpn & mask}, {ENT_W{1'b0}}};
    endfunction

endpackage

// File: rtl/dmx_window.sv
module dmx_window
    import dmx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_sel,
    input  logic [PCI_AW-1:0]    cfg_wdata,
    input  logic [VPN_W-1:0]     vpn,
    output logic                 match,
    output logic                 sg_mode,
    output logic [PFN_W-1:0]     lin_pfn,
    output logic [SYS_AW-1:0]    map_addr
);

    win_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                CF_CTRL: begin
                    cfg_q.en <= cfg_wdata[0];
                    cfg_q.sg <= cfg_wdata[1];
                end
                CF_BASE: cfg_q.base <= cfg_wdata[PCI_AW-1:PG_W];
                CF_MASK: cfg_q.mask <= cfg_wdata[PCI_AW-1:PG_W];
                CF_XLAT: cfg_q.xlat <= cfg_wdata[TBL_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        match    = cfg_q.en && ((vpn & ~cfg_q.mask) == (cfg_q.base & ~cfg_q.mask));
        sg_mode  = cfg_q.sg;
        lin_pfn  = linear_pfn(cfg_q.xlat, cfg_q.mask, vpn);
        map_addr = entry_addr(cfg_q.xlat, cfg_q.mask, vpn);
    end

    // R2
    disabled_no_claim_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.en |-> !match);

endmodule

// File: rtl/dmx_tlb.sv
module dmx_tlb
    import dmx_pkg::*;
#(
    parameter int N = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inv,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [PFN_W-1:0] fill_pfn
);

    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    logic [N-1:0]     vld;
    logic [N-1:0]     hit_v;
    logic [TAG_W-1:0] tag_q [N];
    logic [PFN_W-1:0] pfn_q [N];
    logic [IW-1:0]    rr;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_v[i] = vld[i] && (tag_q[i] == lk_tag);
    end

    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_v[i]) lk_pfn = lk_pfn | pfn_q[i];
        end
        lk_hit = |hit_v;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            rr  <= '0;
        end else if (inv) begin
            vld <= '0;
            rr  <= '0;
        end else if (fill_en) begin
            vld[rr] <= 1'b1;
            rr      <= (rr == LAST) ? '0 : rr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en && !inv) begin
            tag_q[rr] <= fill_tag;
            pfn_q[rr] <= fill_pfn;
        end
    end

    // R5
    unique_tag_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_v));

    // R8
    inv_clears_chk: assert property (@(posedge clk) disable iff (rst)
        inv |=> (vld == '0));

    // R7
    fill_sets_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !inv) |=> ($countones(vld) >= 1));

endmodule

// File: rtl/dmx_split.sv
module dmx_split
    import dmx_pkg::*;
(
    input  logic [PG_W-1:0]  off,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] out_len,
    output logic             split
);

    logic [LEN_W-1:0] room;

    always_comb begin
        room    = LEN_W'(1 << PG_W) - {1'b0, off};
        split   = len > room;
        out_len = split ? room : len;
    end

endmodule

// File: rtl/pci_dma_xlate.sv
module pci_dma_xlate
    import dmx_pkg::*;
#(
    parameter int TLB_N = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_win,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              tlb_inv,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_addr,
    input  logic [13:0]       req_len,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [33:0]       rsp_addr,
    output logic [13:0]       rsp_len,
    output logic              rsp_split,
    output logic              mem_rd_req,
    output logic [33:0]       mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [20:0]       mem_rd_data
);

    xl_state_e        state;
    logic [VPN_W-1:0] r_vpn;
    logic [PG_W-1:0]  r_off;
    logic [LEN_W-1:0] r_len;
    logic [WIN_IW-1:0] r_win;
    xl_rsp_t          rsp_q;

    logic              win_hit [NWIN];
    logic              win_sg  [NWIN];
    logic [PFN_W-1:0]  win_pfn [NWIN];
    logic [SYS_AW-1:0] win_map [NWIN];

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        dmx_window u_win (
            .clk      (clk),
            .rst      (rst),
            .cfg_we   (cfg_we && (cfg_win == WIN_IW'(w))),
            .cfg_sel  (cfg_sel),
            .cfg_wdata(cfg_wdata),
            .vpn      (r_vpn),
            .match    (win_hit[w]),
            .sg_mode  (win_sg[w]),
            .lin_pfn  (win_pfn[w]),
            .map_addr (win_map[w])
        );
    end

    logic              sel_found;
    logic [WIN_IW-1:0] sel_idx;

    always_comb begin
        sel_found = 1'b0;
        sel_idx   = '0;
        for (int w = NWIN - 1; w >= 0; w--) begin
            if (win_hit[w]) begin
                sel_found = 1'b1;
                sel_idx   = WIN_IW'(w);
            end
        end
    end

    logic             tlb_hit;
    logic [PFN_W-1:0] tlb_pfn;
    logic             fill_en;

    assign fill_en = (state == ST_WAIT) && mem_rd_valid;

    dmx_tlb #(.N(TLB_N)) u_tlb (
        .clk     (clk),
        .rst     (rst),
        .inv     (tlb_inv),
        .lk_tag  ({sel_idx, r_vpn}),
        .lk_hit  (tlb_hit),
        .lk_pfn  (tlb_pfn),
        .fill_en (fill_en),
        .fill_tag({r_win, r_vpn}),
        .fill_pfn(mem_rd_data)
    );

    logic [LEN_W-1:0] cut_len;
    logic             cut_split;

    dmx_split u_split (
        .off    (r_off),
        .len    (r_len),
        .out_len(cut_len),
        .split  (cut_split)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            r_vpn       <= '0;
            r_off       <= '0;
            r_len       <= '0;
            r_win       <= '0;
            rsp_q       <= '0;
            rsp_valid   <= 1'b0;
            mem_rd_req  <= 1'b0;
            mem_rd_addr <= '0;
        end else begin
            rsp_valid  <= 1'b0;
            mem_rd_req <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        r_vpn <= req_addr[PCI_AW-1:PG_W];
                        r_off <= req_addr[PG_W-1:0];
                        r_len <= req_len;
                        state <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (!sel_found) begin
                        rsp_q     <= '0;
                        rsp_valid <= 1'b1;
                        state     <= ST_IDLE;
                    end else if (!win_sg[sel_idx]) begin
                        rsp_q     <= '{hit: 1'b1, addr: {win_pfn[sel_idx], r_off},
                                       len: cut_len, split: cut_split};
                        rsp_valid <= 1'b1;
                        state     <= ST_IDLE;
                    end else if (tlb_hit) begin
                        rsp_q     <= '{hit: 1'b1, addr: {tlb_pfn, r_off},
                                       len: cut_len, split: cut_split};
                        rsp_valid <= 1'b1;
                        state     <= ST_IDLE;
                    end else begin
                        mem_rd_req  <= 1'b1;
                        mem_rd_addr <= win_map[sel_idx];
                        r_win       <= sel_idx;
                        state       <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_rd_valid) begin
                        rsp_q     <= '{hit: 1'b1, addr: {mem_rd_data, r_off},
                                       len: cut_len, split: cut_split};
                        rsp_valid <= 1'b1;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign rsp_hit   = rsp_q.hit;
    assign rsp_addr  = rsp_q.addr;
    assign rsp_len   = rsp_q.len;
    assign rsp_split = rsp_q.split;

    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R6
    read_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |=> !mem_rd_req);

    // R6
    read_no_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> (!rsp_valid && !req_ready));

    // R2
    unclaimed_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_addr == '0 && rsp_len == '0 && !rsp_split));

    // R9
    page_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> (({2'b0, rsp_addr[PG_W-1:0]} + {1'b0, rsp_len}) <= 15'd8192));

endmodule

// File: tb/pci_dma_xlate_tb.sv
`timescale 1ns/1ps
module pci_dma_xlate_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_win = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        inv_tb = 1'b0;
    logic        inv_mem = 1'b0;
    logic        tlb_inv;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [13:0] req_len = '0;
    logic        rsp_valid, rsp_hit, rsp_split;
    logic [33:0] rsp_addr;
    logic [13:0] rsp_len;
    logic        mem_rd_req;
    logic [33:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [20:0] mem_rd_data = '0;

    assign tlb_inv = inv_tb | inv_mem;

    always #2 clk = ~clk;

    pci_dma_xlate u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_win(cfg_win), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .tlb_inv(tlb_inv), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr),
        .rsp_len(rsp_len), .rsp_split(rsp_split), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
    );

    int tests = 0;
    int fails = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // bench copy of the programmed window settings
    logic        c_en [2];
    logic        c_sg [2];
    logic [18:0] c_base [2];
    logic [18:0] c_mask [2];
    logic [30:0] c_xl [2];

    function automatic logic [20:0] mem_fn(input logic [33:0] a);
        return a[23:3] ^ 21'h0A5A5;
    endfunction

    function automatic logic [33:0] exp_map(input int w, input logic [18:0] vpn);
        logic [30:0] m;
        m = {12'b0, c_mask[w]};
        return {(c_xl[w] & ~m) | {12'b0, vpn & c_mask[w]}, 3'b000};
    endfunction

    function automatic logic [49:0] exp_rsp(input logic [31:0] a, input logic [13:0] l);
        logic [18:0] vpn;
        logic [13:0] room, el;
        logic [20:0] pfn;
        logic        es;
        int          w;
        vpn = a[31:13];
        w = -1;
        if (c_en[1] && ((vpn & ~c_mask[1]) == (c_base[1] & ~c_mask[1]))) w = 1;
        if (c_en[0] && ((vpn & ~c_mask[0]) == (c_base[0] & ~c_mask[0]))) w = 0;
        if (w < 0) return '0;
        room = 14'd8192 - {1'b0, a[12:0]};
        es = l > room;
        el = es ? room : l;
        if (c_sg[w]) pfn = mem_fn(exp_map(w, vpn));
        else pfn = (c_xl[w][20:0] & ~{2'b0, c_mask[w]}) | {2'b0, vpn & c_mask[w]};
        return {1'b1, pfn, a[12:0], el, es};
    endfunction

    // memory model for map entry reads
    int          reads = 0;
    int          mem_delay = 0;
    bit          inv_with_fill = 0;
    bit          pend = 0;
    int          pend_cnt = 0;
    logic [33:0] pend_addr = '0;
    logic [33:0] last_rd_addr = '0;

    always @(negedge clk) begin
        mem_rd_valid = 1'b0;
        inv_mem = 1'b0;
        if (mem_rd_req) begin
            pend = 1;
            pend_cnt = mem_delay;
            pend_addr = mem_rd_addr;
            last_rd_addr = mem_rd_addr;
            reads++;
        end
        if (pend) begin
            if (pend_cnt == 0) begin
                mem_rd_valid = 1'b1;
                mem_rd_data = mem_fn(pend_addr);
                inv_mem = inv_with_fill;
                pend = 0;
            end else begin
                pend_cnt--;
            end
        end
    end

    task automatic cfg_write(input int w, input int sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_win = w[0]; cfg_sel = sel[1:0]; cfg_wdata = d;
        case (sel)
            0: begin c_en[w] = d[0]; c_sg[w] = d[1]; end
            1: c_base[w] = d[31:13];
            2: c_mask[w] = d[31:13];
            default: c_xl[w] = d[30:0];
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_inv();
        @(negedge clk);
        inv_tb = 1'b1;
        @(negedge clk);
        inv_tb = 1'b0;
    endtask

    logic [49:0] g_rsp;
    int          g_cyc, g_rd;
    bit          g_ready_seen;

    task automatic do_req(input logic [31:0] a, input logic [13:0] l,
                          input bit stray, input logic [31:0] stray_a);
        int r0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        r0 = reads;
        req_valid = 1'b1; req_addr = a; req_len = l;
        @(negedge clk);
        req_valid = 1'b0;
        g_cyc = 1;
        g_ready_seen = 0;
        while (!rsp_valid && g_cyc < 100) begin
            req_valid = 1'b0;
            if (req_ready) g_ready_seen = 1;
            if (stray && g_cyc == 2) begin
                req_valid = 1'b1; req_addr = stray_a;
            end
            @(negedge clk);
            g_cyc++;
        end
        req_valid = 1'b0;
        if (g_cyc >= 100) chk(0, "R6", "response timeout", 64'(g_cyc), 64'd0);
        g_rsp = {rsp_hit, rsp_addr, rsp_len, rsp_split};
        g_rd = reads - r0;
    endtask

    task automatic run_chk(input string req, input logic [31:0] a, input logic [13:0] l);
        logic [49:0] e;
        e = exp_rsp(a, l);
        do_req(a, l, 0, 32'h0);
        chk(g_rsp == e, req, "response", 64'(g_rsp), 64'(e));
    endtask

    localparam logic [31:0] W0_BASE = 32'h1000_0000;

    initial begin
        for (int w = 0; w < 2; w++) begin
            c_en[w] = 0; c_sg[w] = 0; c_base[w] = '0; c_mask[w] = '0; c_xl[w] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", 64'(rsp_valid), 64'd0);
        chk(mem_rd_req == 1'b0, "R1", "mem_rd_req", 64'(mem_rd_req), 64'd0);

        // R2 nothing enabled
        run_chk("R2", 32'h1234_5678, 14'd100);

        // window setup: win0 16 MB at 0x1000_0000, win1 1 GB at 0
        cfg_write(0, 1, W0_BASE);
        cfg_write(0, 2, 32'h00FF_E000);
        cfg_write(0, 3, 32'h1234_5678);
        cfg_write(1, 1, 32'h0000_0000);
        cfg_write(1, 2, 32'h3FFF_E000);
        cfg_write(1, 3, 32'h0ABC_DEF0);

        // R3 linear mode latency and no read
        cfg_write(0, 0, 32'h1);
        do_req(W0_BASE + 32'h0004_6123, 14'd64, 0, 32'h0);
        chk(g_rsp == exp_rsp(W0_BASE + 32'h0004_6123, 14'd64), "R3", "linear addr",
            64'(g_rsp), 64'(exp_rsp(W0_BASE + 32'h0004_6123, 14'd64)));
        chk(g_cyc == 2, "R3", "linear latency", 64'(g_cyc), 64'd2);
        chk(g_rd == 0, "R3", "linear reads", 64'(g_rd), 64'd0);

        // R9 split boundaries
        run_chk("R9", W0_BASE, 14'd8192);
        run_chk("R9", W0_BASE + 32'h1FFF, 14'd2);
        run_chk("R9", W0_BASE + 32'h1000, 14'd4096);
        run_chk("R9", W0_BASE + 32'h1000, 14'd4097);
        run_chk("R9", W0_BASE + 32'h1FFF, 14'd1);

        // R4 R6 table-walk miss
        cfg_write(0, 0, 32'h3);
        pulse_inv();
        mem_delay = 2;
        do_req(W0_BASE + 32'h0000_4321, 14'd16, 0, 32'h0);
        chk(g_rsp == exp_rsp(W0_BASE + 32'h0000_4321, 14'd16), "R4", "walk addr",
            64'(g_rsp), 64'(exp_rsp(W0_BASE + 32'h0000_4321, 14'd16)));
        chk(last_rd_addr == exp_map(0, W0_BASE[31:13] + 19'd2), "R4", "map addr",
            64'(last_rd_addr), 64'(exp_map(0, W0_BASE[31:13] + 19'd2)));
        chk(g_rd == 1, "R6", "miss reads", 64'(g_rd), 64'd1);
        chk(g_cyc == 5, "R6", "miss latency", 64'(g_cyc), 64'd5);
        chk(!g_ready_seen, "R6", "ready during stall", 64'(g_ready_seen), 64'd0);
        mem_delay = 0;

        // R5 hit
        do_req(W0_BASE + 32'h0000_5000, 14'd16, 0, 32'h0);
        chk(g_rd == 0, "R5", "hit reads", 64'(g_rd), 64'd0);
        chk(g_cyc == 2, "R5", "hit latency", 64'(g_cyc), 64'd2);
        chk(g_rsp == exp_rsp(W0_BASE + 32'h0000_5000, 14'd16), "R5", "hit addr",
            64'(g_rsp), 64'(exp_rsp(W0_BASE + 32'h0000_5000, 14'd16)));

        // R7 round robin
        pulse_inv();
        for (int k = 0; k < 9; k++) do_req(W0_BASE + 32'(k) * 32'h2000, 14'd8, 0, 32'h0);
        for (int k = 1; k < 8; k++) begin
            do_req(W0_BASE + 32'(k) * 32'h2000, 14'd8, 0, 32'h0);
            chk(g_rd == 0, "R7", "retained page reads", 64'(g_rd), 64'd0);
        end
        do_req(W0_BASE, 14'd8, 0, 32'h0);
        chk(g_rd == 1, "R7", "evicted first page", 64'(g_rd), 64'd1);
        do_req(W0_BASE + 32'h2000, 14'd8, 0, 32'h0);
        chk(g_rd == 1, "R7", "second page evicted by refill", 64'(g_rd), 64'd1);

        // R8 invalidate
        pulse_inv();
        do_req(W0_BASE + 32'h4000, 14'd8, 0, 32'h0);
        chk(g_rd == 1, "R8", "miss after invalidate", 64'(g_rd), 64'd1);

        // R8 invalidate coinciding with fill
        inv_with_fill = 1;
        do_req(W0_BASE + 32'h0002_8000, 14'd8, 0, 32'h0);
        inv_with_fill = 0;
        chk(g_rsp == exp_rsp(W0_BASE + 32'h0002_8000, 14'd8), "R8", "rsp with inv",
            64'(g_rsp), 64'(exp_rsp(W0_BASE + 32'h0002_8000, 14'd8)));
        do_req(W0_BASE + 32'h0002_8000, 14'd8, 0, 32'h0);
        chk(g_rd == 1, "R8", "fill dropped by inv", 64'(g_rd), 64'd1);

        // R10 stray strobe during stall
        mem_delay = 5;
        do_req(W0_BASE + 32'h0003_C000, 14'd8, 1, W0_BASE + 32'h0003_E000);
        mem_delay = 0;
        chk(g_rsp == exp_rsp(W0_BASE + 32'h0003_C000, 14'd8), "R10", "stray ignored",
            64'(g_rsp), 64'(exp_rsp(W0_BASE + 32'h0003_C000, 14'd8)));
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R10", "rsp pulse width", 64'(rsp_valid), 64'd0);
        chk(req_ready == 1'b1, "R10", "no pending stray", 64'(req_ready), 64'd1);
        do_req(W0_BASE + 32'h0003_E000, 14'd8, 0, 32'h0);
        chk(g_rd == 1, "R10", "stray page not filled", 64'(g_rd), 64'd1);

        // R2 R3 R4 R9 sweep over modes and enables
        for (int m = 0; m < 4; m++) begin
            for (int e = 1; e < 4; e++) begin
                cfg_write(0, 0, {30'b0, m[0], e[0]});
                cfg_write(1, 0, {30'b0, m[1], e[1]});
                pulse_inv();
                for (int r = 0; r < 3; r++) begin
                    for (int i = 0; i < 8; i++) begin
                        logic [31:0] a;
                        logic [13:0] l;
                        a = (r == 0 ? 32'h1000_0000 : (r == 1 ? 32'h2000_0000 : 32'h8000_0000))
                            + 32'(i) * 32'h0003_2345;
                        l = 14'(((i * 1237 + r * 311) % 9000) + 1);
                        run_chk("R2", a, l);
                    end
                end
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule